// File: doc/BRIEF.md
# Event Interrupt Pulse and Sticky Flag Manager

This block gathers a vector of event status lines, such as input overvoltage, a charge-timer fault, a temperature fault, conversion-ready and button events. It keeps one sticky flag for each event, and those flags are cleared when the host reads them. It also turns new events into fixed-length low pulses on a single open-drain interrupt line. Only a rising edge of a status line counts as an event, so a condition that stays present raises one interrupt and no more.

Three gates stop a pulse: the per-event mask, one global mask, and the startup-complete input. A pulse is also withheld for the conversion-ready event while input power is present, because conversions then run all the time. Events that arrive while a pulse is being driven, or during the quiet gap after it, are merged into a single further pulse. That pulse is driven once the line has been released for one full pulse length. The pulse length is set in clock cycles from a clock-rate parameter and a duration parameter.

The host-side register bus is outside this block. The block only takes a read strobe that marks a read of the flag register. Some flags are marked as held: a read does not clear them while their condition is still present.

Top module: `irq_pulse_mgr`

## Requirements
- R1: After reset, all flags are 0, the pin-drive enable is 0 and the pulse state is idle.
- R2: A rising edge on an unmasked status bit is sampled at a clock edge. When startup is complete and the global mask is clear, the pin-drive enable goes high from that edge for exactly PULSE_CYC = CLK_MHZ*PULSE_US cycles.
- R3: A status bit that stays high produces no further pulse after its first one.
- R4: A rising edge on a bit whose mask is 1 produces no pulse. Clearing the mask while the bit is still high also produces no pulse.
- R5: While the global mask is 1, no event starts a pulse.
- R6: While startup_done is 0, no event starts a pulse. An event seen then does not cause a pulse later.
- R7: A rising edge of a status bit sets its flag at that clock edge, whatever the masks are. A read strobe clears every flag that is not a held flag.
- R8: Bit 0 is a held flag by default. A read leaves it set while status bit 0 is high, and a read clears it once status bit 0 is low.
- R9: Bit 3 is the conversion-ready event by default. Its rising edge produces no pulse while vin_present is 1, but its flag is still set.
- R10: Events that start during a pulse or during its gap produce exactly one further pulse. That pulse starts exactly PULSE_CYC cycles after the previous pulse ends.
- R11: The pulse state is encoded as 0 for idle, 1 while the pin is driven, and 2 during the gap after a pulse.
- R12: If a rising edge and a read strobe occur in the same cycle, the flag is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_status | input | N_EVT | Live event condition lines |
| evt_mask | input | N_EVT | Per-event mask, 1 blocks the pulse |
| global_mask | input | 1 | 1 blocks every pulse |
| startup_done | input | 1 | Startup into a valid state has finished |
| vin_present | input | 1 | Input power present; suppresses conversion-ready pulses |
| flag_rd | input | 1 | One-cycle strobe: host read the flag register |
| flags_o | output | N_EVT | Sticky event flags |
| int_drive_en | output | 1 | 1 pulls the open-drain interrupt pin low |
| pulse_state | output | 2 | 0 idle, 1 driving, 2 gap |

## Verification
The checker assumes that all inputs change only between clock edges and that flag_rd is a plain strobe. It also assumes that a status edge is seen through the registered previous value, so an edge counts only if the line was low at the previous sampled edge. The bench drives every input on the falling edge. This keeps each status change, mask change and read at a single well-defined rising edge. The random phase toggles masks, power presence and startup often enough to reach the suppression paths. A cycle model in the bench tracks the flags, the pin and the state.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_DRIVE = 2'd1,
      PS_GAP   = 2'd2
   } pulse_state_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int N_EVT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] status_i,
   output logic [N_EVT-1:0] rise_o
);

   logic [N_EVT-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= status_i;
   end

   assign rise_o = status_i & ~prev_q;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int               N_EVT     = 8,
   parameter logic [N_EVT-1:0] HOLD_MASK = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] status_i,
   input  logic [N_EVT-1:0] rise_i,
   input  logic             rd_i,
   output logic [N_EVT-1:0] flags_o
);

   logic [N_EVT-1:0] flag_q;
   logic [N_EVT-1:0] clr;

   for (genvar i = 0; i < N_EVT; i++) begin : g_bit
      if (HOLD_MASK[i]) begin : g_held
         assign clr[i] = rd_i & ~status_i[i];
      end else begin : g_plain
         assign clr[i] = rd_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= (flag_q[i] & ~clr[i]) | rise_i[i];
      end
   end

   assign flags_o = flag_q;

endmodule

// File: rtl/irq_trigger_gate.sv
module irq_trigger_gate #(
   parameter int N_EVT   = 8,
   parameter int RDY_IDX = 3
) (
   input  logic [N_EVT-1:0] rise_i,
   input  logic [N_EVT-1:0] mask_i,
   input  logic             global_mask_i,
   input  logic             startup_done_i,
   input  logic             vin_present_i,
   output logic             trig_o
);

   logic [N_EVT-1:0] quiet;

   if (RDY_IDX < N_EVT) begin : g_rdy
      always_comb begin
         quiet          = '0;
         quiet[RDY_IDX] = vin_present_i;
      end
   end else begin : g_nordy
      assign quiet = '0;
   end

   assign trig_o = (|(rise_i & ~mask_i & ~quiet)) & ~global_mask_i & startup_done_i;

endmodule

// File: rtl/irq_pulse_fsm.sv
module irq_pulse_fsm
   import irq_pkg::*;
#(
   parameter int PULSE_CYC = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         trig_i,
   output logic         drive_o,
   output pulse_state_e state_o
);

   localparam int CW = $clog2(PULSE_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

   pulse_state_e state_q;
   logic [CW-1:0] cnt_q;
   logic          pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
      end else begin
         case (state_q)
            PS_IDLE: begin
               cnt_q <= '0;
               if (trig_i) state_q <= PS_DRIVE;
            end
            PS_DRIVE: begin
               if (trig_i) pend_q <= 1'b1;
               if (cnt_q == LAST) begin
                  state_q <= PS_GAP;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PS_GAP: begin
               if (cnt_q == LAST) begin
                  cnt_q   <= '0;
                  pend_q  <= 1'b0;
                  state_q <= (pend_q || trig_i) ? PS_DRIVE : PS_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
                  if (trig_i) pend_q <= 1'b1;
               end
            end
            default: begin
               state_q <= PS_IDLE;
               cnt_q   <= '0;
               pend_q  <= 1'b0;
            end
         endcase
      end
   end

   assign drive_o = (state_q == PS_DRIVE);
   assign state_o = state_q;

endmodule

// File: rtl/irq_pulse_mgr.sv
module irq_pulse_mgr
   import irq_pkg::*;
#(
   parameter int               N_EVT     = 8,
   parameter int               CLK_MHZ   = 1,
   parameter int               PULSE_US  = 128,
   parameter logic [N_EVT-1:0] HOLD_MASK = 1,
   parameter int               RDY_IDX   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_status,
   input  logic [N_EVT-1:0] evt_mask,
   input  logic             global_mask,
   input  logic             startup_done,
   input  logic             vin_present,
   input  logic             flag_rd,
   output logic [N_EVT-1:0] flags_o,
   output logic             int_drive_en,
   output logic [1:0]       pulse_state
);

   localparam int PULSE_CYC = CLK_MHZ * PULSE_US;

   if (N_EVT < 1 || N_EVT > 32) begin : g_bad_n
      $error("irq_pulse_mgr: N_EVT out of range");
   end
   if (PULSE_CYC < 2) begin : g_bad_len
      $error("irq_pulse_mgr: pulse shorter than two cycles");
   end

   logic [N_EVT-1:0] rise_w;
   logic             trig_w;
   pulse_state_e     st_w;

   irq_edge_detect #(.N_EVT(N_EVT)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (evt_status),
      .rise_o   (rise_w)
   );

   irq_flag_bank #(.N_EVT(N_EVT), .HOLD_MASK(HOLD_MASK)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (evt_status),
      .rise_i   (rise_w),
      .rd_i     (flag_rd),
      .flags_o  (flags_o)
   );

   irq_trigger_gate #(.N_EVT(N_EVT), .RDY_IDX(RDY_IDX)) u_gate (
      .rise_i         (rise_w),
      .mask_i         (evt_mask),
      .global_mask_i  (global_mask),
      .startup_done_i (startup_done),
      .vin_present_i  (vin_present),
      .trig_o         (trig_w)
   );

   irq_pulse_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (trig_w),
      .drive_o (int_drive_en),
      .state_o (st_w)
   );

   assign pulse_state = st_w;

endmodule

// File: rtl/irq_pulse_mgr_chk.sv
module irq_pulse_mgr_chk #(
   parameter int N_EVT     = 8,
   parameter int PULSE_CYC = 128,
   parameter int RDY_IDX   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_EVT-1:0] evt_status,
   input logic [N_EVT-1:0] evt_mask,
   input logic             global_mask,
   input logic             startup_done,
   input logic             vin_present,
   input logic             flag_rd,
   input logic [N_EVT-1:0] flags_o,
   input logic             int_drive_en,
   input logic [1:0]       pulse_state,
   input logic [N_EVT-1:0] rise_w
);

   localparam logic [N_EVT-1:0] RDY_BIT = (RDY_IDX < N_EVT) ? (N_EVT'(1) << RDY_IDX) : '0;

   int unsigned hi_cnt;
   int unsigned lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= 0;
         lo_cnt <= 0;
      end else if (int_drive_en) begin
         hi_cnt <= hi_cnt + 1;
         lo_cnt <= 0;
      end else begin
         hi_cnt <= 0;
         if (lo_cnt < 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 1;
      end
   end

   // R2
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_drive_en) |-> hi_cnt == PULSE_CYC);

   // R10
   gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(int_drive_en) && $past(pulse_state) == 2'd2) |-> lo_cnt == PULSE_CYC);

   // R4
   start_needs_unmasked_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(int_drive_en) && $past(pulse_state) == 2'd0) |-> $past(|(rise_w & ~evt_mask)));

   // R5
   global_mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (global_mask && pulse_state == 2'd0) |=> !int_drive_en);

   // R6
   startup_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!startup_done && pulse_state == 2'd0) |=> !int_drive_en);

   // R9
   rdy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_state == 2'd0 && vin_present && ((rise_w & ~evt_mask & ~RDY_BIT) == '0))
      |=> !int_drive_en);

   // R11
   state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_state != 2'd3);

   for (genvar i = 0; i < N_EVT; i++) begin : g_flag
      // R12
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rise_w[i] |=> flags_o[i]);
      // R7
      read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_rd && !evt_status[i]) |=> !flags_o[i]);
   end

   // R8
   held_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[0] && evt_status[0] && flag_rd) |=> flags_o[0]);

endmodule

bind irq_pulse_mgr irq_pulse_mgr_chk #(
   .N_EVT     (N_EVT),
   .PULSE_CYC (PULSE_CYC),
   .RDY_IDX   (RDY_IDX)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .evt_status   (evt_status),
   .evt_mask     (evt_mask),
   .global_mask  (global_mask),
   .startup_done (startup_done),
   .vin_present  (vin_present),
   .flag_rd      (flag_rd),
   .flags_o      (flags_o),
   .int_drive_en (int_drive_en),
   .pulse_state  (pulse_state),
   .rise_w       (rise_w)
);

// File: tb/tb_irq_pulse_mgr.sv
module tb_irq_pulse_mgr;

   localparam int CLK_NS = 10;
   localparam int N      = 8;
   localparam int PL     = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt_status = '0;
   logic [N-1:0] evt_mask = '0;
   logic         global_mask = 1'b0;
   logic         startup_done = 1'b0;
   logic         vin_present = 1'b0;
   logic         flag_rd = 1'b0;
   logic [N-1:0] flags_o;
   logic         int_drive_en;
   logic [1:0]   pulse_state;

   int total = 0;
   int bad = 0;

   irq_pulse_mgr #(.N_EVT(N), .CLK_MHZ(1), .PULSE_US(PL), .HOLD_MASK(8'h01), .RDY_IDX(3)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_status   (evt_status),
      .evt_mask     (evt_mask),
      .global_mask  (global_mask),
      .startup_done (startup_done),
      .vin_present  (vin_present),
      .flag_rd      (flag_rd),
      .flags_o      (flags_o),
      .int_drive_en (int_drive_en),
      .pulse_state  (pulse_state)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [N-1:0] m_prev, m_flags;
   int           m_state, m_cnt;
   bit           m_pend;

   function automatic logic [N-1:0] next_flags(logic [N-1:0] f, logic [N-1:0] rise,
                                               logic [N-1:0] st, logic rd);
      logic [N-1:0] clr;
      clr = rd ? ~(8'h01 & st) : '0;
      return (f & ~clr) | rise;
   endfunction

   function automatic bit fires(logic [N-1:0] rise);
      logic [N-1:0] q;
      q = vin_present ? 8'h08 : 8'h00;
      return (|(rise & ~evt_mask & ~q)) && !global_mask && startup_done;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev = '0; m_flags = '0; m_state = 0; m_cnt = 0; m_pend = 0;
      end else begin
         logic [N-1:0] rise;
         bit t;
         rise = evt_status & ~m_prev;
         m_prev = evt_status;
         m_flags = next_flags(m_flags, rise, evt_status, flag_rd);
         t = fires(rise);
         case (m_state)
            0: begin m_cnt = 0; if (t) m_state = 1; end
            1: begin
               if (t) m_pend = 1;
               if (m_cnt == PL-1) begin m_state = 2; m_cnt = 0; end else m_cnt++;
            end
            default: begin
               if (m_cnt == PL-1) begin
                  m_state = (m_pend || t) ? 1 : 0; m_pend = 0; m_cnt = 0;
               end else begin
                  m_cnt++; if (t) m_pend = 1;
               end
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R7 model flags", 32'(flags_o), 32'(m_flags));
         chk("R2 model pin", 32'(int_drive_en), 32'(m_state == 1));
         chk("R11 model state", 32'(pulse_state), 32'(m_state));
      end
   end

   // ---------------- pulse observer ----------------
   int nrun;
   int rs[4];
   int rl[4];

   task automatic observe(int window);
      bit prev;
      prev = 0; nrun = 0;
      for (int k = 0; k < 4; k++) begin rs[k] = 0; rl[k] = 0; end
      for (int i = 1; i <= window; i++) begin
         @(negedge clk);
         if (int_drive_en) begin
            if (!prev && nrun < 4) begin rs[nrun] = i; nrun++; end
            if (nrun > 0 && nrun <= 4) rl[nrun-1]++;
         end
         prev = int_drive_en;
      end
   endtask

   task automatic ticks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read();
      flag_rd = 1'b1;
      @(negedge clk);
      flag_rd = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 200000);
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      ticks(3);
      // R1 reset state
      chk("R1 flags", 32'(flags_o), 0);
      chk("R1 pin", 32'(int_drive_en), 0);
      chk("R11 idle code", 32'(pulse_state), 0);
      rst_n = 1'b1;
      ticks(2);
      startup_done = 1'b1;
      ticks(2);

      // R2 single pulse, R3 level held
      evt_status[1] = 1'b1;
      observe(60);
      chk("R2 pulse count", nrun, 1);
      chk("R2 pulse start", rs[0], 1);
      chk("R2 pulse length", rl[0], PL);
      observe(40);
      chk("R3 no repeat while held", nrun, 0);
      evt_status[1] = 1'b0;
      ticks(4);

      // R4 masked edge, then unmask while high
      evt_mask[2] = 1'b1;
      evt_status[2] = 1'b1;
      observe(40);
      chk("R4 masked edge", nrun, 0);
      evt_mask[2] = 1'b0;
      observe(40);
      chk("R4 unmask while present", nrun, 0);
      evt_status[2] = 1'b0;

      // R5 global mask
      global_mask = 1'b1;
      evt_status[4] = 1'b1;
      observe(40);
      chk("R5 global mask", nrun, 0);
      evt_status[4] = 1'b0;
      global_mask = 1'b0;

      // R6 startup gate
      startup_done = 1'b0;
      evt_status[5] = 1'b1;
      observe(20);
      chk("R6 before startup", nrun, 0);
      startup_done = 1'b1;
      observe(40);
      chk("R6 no late pulse", nrun, 0);
      evt_status[5] = 1'b0;

      // R7 flags and read clear
      chk("R7 flags recorded while masked", 32'(flags_o), 32'h36);
      do_read();
      chk("R7 read clears", 32'(flags_o), 0);
      global_mask = 1'b1;
      evt_status[6] = 1'b1;
      ticks(1);
      chk("R7 flag set on edge", 32'(flags_o[6]), 1);
      do_read();
      chk("R7 read clears while high", 32'(flags_o[6]), 0);
      evt_status[6] = 1'b0;

      // R12 edge and read same cycle
      evt_status[7] = 1'b1;
      flag_rd = 1'b1;
      ticks(1);
      flag_rd = 1'b0;
      chk("R12 set wins", 32'(flags_o[7]), 1);
      evt_status[7] = 1'b0;
      do_read();

      // R8 held flag
      evt_status[0] = 1'b1;
      ticks(1);
      do_read();
      chk("R8 held while present", 32'(flags_o[0]), 1);
      evt_status[0] = 1'b0;
      ticks(1);
      chk("R8 still set after condition ends", 32'(flags_o[0]), 1);
      do_read();
      chk("R8 cleared by read after condition", 32'(flags_o[0]), 0);
      global_mask = 1'b0;
      ticks(2);

      // R9 conversion-ready suppression
      vin_present = 1'b1;
      evt_status[3] = 1'b1;
      observe(40);
      chk("R9 no pulse with power", nrun, 0);
      chk("R9 flag still set", 32'(flags_o[3]), 1);
      evt_status[3] = 1'b0;
      vin_present = 1'b0;
      ticks(1);
      evt_status[3] = 1'b1;
      observe(40);
      chk("R9 pulse without power", nrun, 1);
      evt_status[3] = 1'b0;
      ticks(40);

      // R10 merge during pulse and gap
      evt_status[1] = 1'b1;
      fork
         observe(90);
         begin
            ticks(4);
            evt_status[2] = 1'b1;
            ticks(16);
            evt_status[4] = 1'b1;
         end
      join
      chk("R10 run count", nrun, 2);
      chk("R10 second start", rs[1], 2*PL + 1);
      chk("R10 second length", rl[1], PL);
      evt_status = '0;
      do_read();
      ticks(40);

      // random phase checked by the model
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         flag_rd = ($urandom_range(15) == 0);
         if ($urandom_range(5) == 0) evt_status[$urandom_range(N-1)] ^= 1'b1;
         if ($urandom_range(63) == 0) evt_mask = N'($urandom);
         if ($urandom_range(149) == 0) global_mask = ~global_mask;
         if ($urandom_range(99) == 0) vin_present = ~vin_present;
         if ($urandom_range(199) == 0) startup_done = ~startup_done;
      end
      flag_rd = 1'b0;
      ticks(4);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule